// File: doc/BRIEF.md
# Voltage Regulator Power Sequencer

This block is the digital sequencing core of a voltage regulator controller. It owns the regulator's reference-voltage code and walks it through power-up, regulation and a soft power-down. It starts only once the supply power-good flag and the enable input are both high. At start-up it follows one of two modes, chosen by a select pin. In the zero mode it turns the drivers on, holds the reference at 0 V for a fixed wait of about 2 ms and then ramps to the first commanded voltage. In the preset mode it ramps at once to 1.1 V and holds there until a command arrives.

Voltage commands come from an upstream serial-bus decoder as an 8-bit code with a one-cycle strobe. The code has a 5 mV LSB. All ramps move the code by at most one step per microsecond tick. A fractional accumulator sets the average step rate. Losing power-good or enable drops the ready flag in the same cycle. The reference then ramps toward zero at 3.125 mV/us, and the drivers switch off once the code is below the 0.2 V floor. A strap is sampled while power-good is low and decides which of two rail addresses the core rail and the graphics rail each take.

Top module: `vr_power_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `vref_code` is 0, `drv_en` is 0, `ready` is 0, `core_addr` is 0 and `gfx_addr` is 1.
- R2: The sequencer leaves the off state (`drv_en` rises) only when `pgood` and `enable` are both high; either one alone keeps `drv_en` at 0.
- R3: With `init_hi`=0 the sequencer enters a hold with `drv_en`=1 and `vref_code`=0 for `WAIT_US` ticks. A command strobed during the hold is stored and acted on only when the hold ends.
- R4: With `init_hi`=1 the code ramps from 0 to 220 (1.1 V) at once. `ready` rises one cycle after the code reaches 220.
- R5: In regulation the code moves toward the target by one code on a tick whenever the accumulated rate reaches 16. After k ticks from rest it has moved floor(k*`SLEW_RATE`/16) codes. It never changes without a tick.
- R6: In zero mode `ready` rises only after the code reaches the first commanded value, never during the hold. Once high, it stays high through later commands.
- R7: `ready` is 0 in any cycle where `pgood` or `enable` is 0.
- R8: After power-good or enable is lost, the code ramps toward 0 by `DOWN_RATE`/16 codes per tick (10/16 = 3.125 mV/us).
- R9: The first cycle after the shutdown ramp takes the code below 40 (0.2 V), `drv_en` is 0 and `vref_code` is 0.
- R10: While `pgood` is low the strap is sampled: `swap_strap`=1 gives `core_addr`=1 and `gfx_addr`=0, `swap_strap`=0 gives 0 and 1. While `pgood` stays high the addresses hold.
- R11: A command that arrives during a ramp retargets it from the present code and keeps the fractional accumulator.
- R12: An `enable` that returns high during the shutdown ramp has no effect until the off state is reached. From there the sequencer restarts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgood | input | 1 | Supply power-on-reset-good flag |
| enable | input | 1 | Regulator enable |
| init_hi | input | 1 | Start-up mode: 1 = preset 1.1 V, 0 = hold at zero |
| vid_code | input | 8 | Commanded reference code, 5 mV/LSB |
| vid_valid | input | 1 | One-cycle strobe qualifying `vid_code` |
| swap_strap | input | 1 | Rail address swap strap |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| vref_code | output | 8 | Reference-voltage code |
| drv_en | output | 1 | Power-stage driver enable |
| ready | output | 1 | Rail ready flag |
| core_addr | output | 4 | Core rail bus address |
| gfx_addr | output | 4 | Graphics rail bus address |

## Verification
Two events can fall together. A new command can land in the middle of a ramp, while the accumulator holds half a step. The enable input can also return during the shutdown ramp. The bench stops a ramp after an odd number of ticks, retargets it, and checks that the very next tick completes the pending step. It also raises enable during the shutdown sweep and confirms that the ramp keeps its exact arithmetic course and that the restart comes one cycle after the off state. Every ramp is swept tick by tick against floor(k*rate/16).

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;

    localparam int unsigned VREF_W   = 8;
    localparam int unsigned MV_PER_LSB = 5;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_SHUT   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              armed;
        logic              pending;
        logic [VREF_W-1:0] code;
    } target_t;

    function automatic int unsigned mv_to_code(input int unsigned mv);
        return mv / MV_PER_LSB;
    endfunction

endpackage

// File: rtl/vrseq_strap.sv
module vrseq_strap #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_good,
    input  logic              strap,
    output logic [ADDR_W-1:0] core_addr,
    output logic [ADDR_W-1:0] gfx_addr
);
    logic swap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            swap_q <= 1'b0;
        end else if (!por_good) begin
            swap_q <= strap;
        end
    end

    assign core_addr = swap_q ? ADDR_W'(1) : ADDR_W'(0);
    assign gfx_addr  = swap_q ? ADDR_W'(0) : ADDR_W'(1);
endmodule

// File: rtl/vrseq_wait_timer.sv
module vrseq_wait_timer #(
    parameter int unsigned LIMIT = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LIM) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == LIM);
endmodule

// File: rtl/vrseq_slew.sv
module vrseq_slew #(
    parameter int unsigned W      = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            tick,
    input  logic [W-1:0]    target,
    input  logic [FRAC_W:0] rate,
    output logic [W-1:0]    code,
    output logic            at_target
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    logic              carry;
    logic              going_up;

    always_comb begin
        sum      = {1'b0, acc_q} + rate;
        carry    = sum[FRAC_W];
        going_up = (target > code);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            code  <= '0;
            acc_q <= '0;
        end else if (at_target) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= sum[FRAC_W-1:0];
            if (carry) begin
                code <= going_up ? code + W'(1) : code - W'(1);
            end
        end
    end

    assign at_target = (code == target);
endmodule

// File: rtl/vr_power_sequencer.sv
module vr_power_sequencer
    import vrseq_pkg::*;
#(
    parameter int unsigned CODE_W     = VREF_W,
    parameter int unsigned FRAC_W     = 4,
    parameter int unsigned SLEW_RATE  = 8,
    parameter int unsigned DOWN_RATE  = 10,
    parameter int unsigned INIT_CODE  = mv_to_code(1100),
    parameter int unsigned FLOOR_CODE = mv_to_code(200),
    parameter int unsigned WAIT_US    = 2000,
    parameter int unsigned ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgood,
    input  logic              enable,
    input  logic              init_hi,
    input  logic [CODE_W-1:0] vid_code,
    input  logic              vid_valid,
    input  logic              swap_strap,
    input  logic              tick_us,
    output logic [CODE_W-1:0] vref_code,
    output logic              drv_en,
    output logic              ready,
    output logic [ADDR_W-1:0] core_addr,
    output logic [ADDR_W-1:0] gfx_addr
);
    localparam logic [CODE_W-1:0] INIT_C  = CODE_W'(INIT_CODE);
    localparam logic [CODE_W-1:0] FLOOR_C = CODE_W'(FLOOR_CODE);
    localparam logic [FRAC_W:0]   RATE_UP = (FRAC_W+1)'(SLEW_RATE);
    localparam logic [FRAC_W:0]   RATE_DN = (FRAC_W+1)'(DOWN_RATE);

    seq_state_e        state_q;
    logic [CODE_W-1:0] tgt_code_q;
    logic              armed_q;
    logic              pending_q;
    logic              ready_q;

    logic              run_ok;
    logic              going_off;
    logic              hold_done;
    logic              at_target;
    logic [CODE_W-1:0] slew_target;
    logic [FRAC_W:0]   slew_rate;

    assign run_ok    = pgood && enable;
    assign going_off = (state_q == ST_SHUT) && (vref_code < FLOOR_C);

    always_comb begin
        slew_target = (state_q == ST_ACTIVE) ? tgt_code_q : '0;
        slew_rate   = (state_q == ST_SHUT) ? RATE_DN : RATE_UP;
    end

    vrseq_slew #(
        .W      (CODE_W),
        .FRAC_W (FRAC_W)
    ) u_slew (
        .clk       (clk),
        .rst       (rst),
        .clear     ((state_q == ST_OFF) || going_off),
        .tick      (tick_us),
        .target    (slew_target),
        .rate      (slew_rate),
        .code      (vref_code),
        .at_target (at_target)
    );

    vrseq_wait_timer #(
        .LIMIT (WAIT_US)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q != ST_HOLD),
        .tick  (tick_us),
        .done  (hold_done)
    );

    vrseq_strap #(
        .ADDR_W (ADDR_W)
    ) u_strap (
        .clk       (clk),
        .rst       (rst),
        .por_good  (pgood),
        .strap     (swap_strap),
        .core_addr (core_addr),
        .gfx_addr  (gfx_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_OFF;
            tgt_code_q <= '0;
            armed_q    <= 1'b0;
            pending_q  <= 1'b0;
            ready_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    ready_q   <= 1'b0;
                    armed_q   <= 1'b0;
                    pending_q <= 1'b0;
                    if (run_ok) begin
                        if (init_hi) begin
                            state_q    <= ST_ACTIVE;
                            tgt_code_q <= INIT_C;
                            armed_q    <= 1'b1;
                        end else begin
                            state_q    <= ST_HOLD;
                            tgt_code_q <= '0;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!run_ok) begin
                        state_q <= ST_SHUT;
                    end else begin
                        if (vid_valid) begin
                            tgt_code_q <= vid_code;
                            pending_q  <= 1'b1;
                        end
                        if (hold_done) begin
                            state_q <= ST_ACTIVE;
                            armed_q <= pending_q || vid_valid;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (!run_ok) begin
                        state_q <= ST_SHUT;
                        ready_q <= 1'b0;
                    end else begin
                        if (vid_valid) begin
                            tgt_code_q <= vid_code;
                            armed_q    <= 1'b1;
                        end
                        if (armed_q && at_target) begin
                            ready_q <= 1'b1;
                        end
                    end
                end
                ST_SHUT: begin
                    ready_q <= 1'b0;
                    if (going_off) begin
                        state_q <= ST_OFF;
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    assign drv_en = (state_q != ST_OFF);
    assign ready  = ready_q && run_ok;
endmodule

// File: rtl/vrseq_checker.sv
module vrseq_checker #(
    parameter int unsigned CODE_W     = 8,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned FLOOR_CODE = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              pgood,
    input logic              enable,
    input logic              tick_us,
    input logic [CODE_W-1:0] vref_code,
    input logic              drv_en,
    input logic              ready,
    input logic [ADDR_W-1:0] core_addr,
    input logic [ADDR_W-1:0] gfx_addr
);
    localparam logic [CODE_W-1:0] FLOOR_C = CODE_W'(FLOOR_CODE);

    p_ready_inputs_r7: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pgood && enable));

    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        (drv_en && $past(drv_en)) |->
            ((vref_code == $past(vref_code)) ||
             (vref_code == $past(vref_code) + CODE_W'(1)) ||
             (vref_code == $past(vref_code) - CODE_W'(1))));

    p_no_tick_still_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick_us) && drv_en && $past(drv_en)) |-> $stable(vref_code));

    p_off_below_floor_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> ($past(vref_code) < FLOOR_C));

    p_off_is_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (vref_code == '0));

    p_ready_needs_drv_r6: assert property (@(posedge clk) disable iff (rst)
        ready |-> drv_en);

    p_addr_distinct_r10: assert property (@(posedge clk) disable iff (rst)
        core_addr != gfx_addr);

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pgood && $past(pgood)) |-> ($stable(core_addr) && $stable(gfx_addr)));
endmodule

bind vr_power_sequencer vrseq_checker #(
    .CODE_W     (CODE_W),
    .ADDR_W     (ADDR_W),
    .FLOOR_CODE (FLOOR_CODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pgood     (pgood),
    .enable    (enable),
    .tick_us   (tick_us),
    .vref_code (vref_code),
    .drv_en    (drv_en),
    .ready     (ready),
    .core_addr (core_addr),
    .gfx_addr  (gfx_addr)
);

// File: tb/vr_power_sequencer_tb.sv
module vr_power_sequencer_tb;
    localparam int WAIT_T = 40;
    localparam int RATE   = 8;
    localparam int DRATE  = 10;
    localparam int FLOOR  = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pgood = 1'b0;
    logic       enable = 1'b0;
    logic       init_hi = 1'b0;
    logic [7:0] vid_code = '0;
    logic       vid_valid = 1'b0;
    logic       swap_strap = 1'b0;
    logic       tick_us = 1'b0;
    logic [7:0] vref_code;
    logic       drv_en;
    logic       ready;
    logic [3:0] core_addr;
    logic [3:0] gfx_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vr_power_sequencer #(
        .SLEW_RATE (RATE),
        .DOWN_RATE (DRATE),
        .WAIT_US   (WAIT_T)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pgood      (pgood),
        .enable     (enable),
        .init_hi    (init_hi),
        .vid_code   (vid_code),
        .vid_valid  (vid_valid),
        .swap_strap (swap_strap),
        .tick_us    (tick_us),
        .vref_code  (vref_code),
        .drv_en     (drv_en),
        .ready      (ready),
        .core_addr  (core_addr),
        .gfx_addr   (gfx_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_us = 1'b1;
        @(negedge clk) tick_us = 1'b0;
    endtask

    task automatic send_cmd(input int v);
        @(negedge clk) begin vid_code = 8'(v); vid_valid = 1'b1; end
        @(negedge clk) vid_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // shutdown sweep from start code; optional enable return at tick ret_k
    task automatic shut_sweep(input int start, input int ret_k, input string tag);
        int e;
        for (int k = 1; k < 400; k++) begin
            do_tick();
            e = start - (k * DRATE) / 16;
            if (k == ret_k) enable = 1'b1;
            chk({tag, " R8 shutdown code"}, vref_code, e);
            if (e < FLOOR) break;
            chk({tag, " R9 driver on above floor"}, drv_en, 1);
        end
        @(negedge clk);
        chk({tag, " R9 driver off"}, drv_en, 0);
        chk({tag, " R9 code zero"}, vref_code, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e;
        idle(4);
        chk("R1 reset code", vref_code, 0);
        chk("R1 reset drv", drv_en, 0);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset core addr", core_addr, 0);
        chk("R1 reset gfx addr", gfx_addr, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset drv", drv_en, 0);

        // R10 strap sampling
        swap_strap = 1'b1;
        idle(2);
        chk("R10 swap core", core_addr, 1);
        chk("R10 swap gfx", gfx_addr, 0);
        pgood = 1'b1; swap_strap = 1'b0;
        idle(3);
        chk("R10 held core", core_addr, 1);
        chk("R10 held gfx", gfx_addr, 0);
        pgood = 1'b0;
        idle(2);
        chk("R10 unswap core", core_addr, 0);
        chk("R10 unswap gfx", gfx_addr, 1);

        // R2 both inputs required
        pgood = 1'b1; enable = 1'b0;
        idle(4);
        chk("R2 pgood only", drv_en, 0);
        pgood = 1'b0; enable = 1'b1;
        idle(4);
        chk("R2 enable only", drv_en, 0);

        // R3 zero mode hold with early command
        init_hi = 1'b0; pgood = 1'b1;
        idle(2);
        chk("R3 drv in hold", drv_en, 1);
        chk("R3 code in hold", vref_code, 0);
        for (int k = 0; k < 5; k++) do_tick();
        send_cmd(60);
        for (int k = 0; k < WAIT_T - 6; k++) do_tick();
        chk("R3 code held before expiry", vref_code, 0);
        chk("R6 no ready in hold", ready, 0);
        do_tick();
        idle(2);
        chk("R3 code at expiry", vref_code, 0);

        // R5 ramp sweep to 60
        for (int k = 1; k <= 125; k++) begin
            do_tick();
            e = (k * RATE) / 16;
            if (e > 60) e = 60;
            chk("R5 ramp code", vref_code, e);
            chk("R6 ready timing", ready, (k > 120) ? 1 : 0);
            if (k == 11) begin
                idle(10);
                chk("R5 no change without tick", vref_code, 5);
            end
        end

        // R11 retarget with half step pending
        send_cmd(100);
        for (int k = 0; k < 21; k++) do_tick();
        chk("R11 before retarget", vref_code, 70);
        send_cmd(90);
        do_tick();
        chk("R11 pending step kept", vref_code, 71);
        for (int k = 0; k < 38; k++) do_tick();
        chk("R11 reached new target", vref_code, 90);
        chk("R6 ready kept", ready, 1);

        // R7 drop enable, R12 return during ramp
        @(negedge clk) enable = 1'b0;
        #1;
        chk("R7 ready drops same cycle", ready, 0);
        chk("R8 drv still on", drv_en, 1);
        @(negedge clk);
        shut_sweep(90, 20, "enable");
        @(negedge clk);
        chk("R12 restart after off", drv_en, 1);

        // R6 hold expiry without command
        for (int k = 0; k < WAIT_T + 5; k++) do_tick();
        chk("R6 no ready without command", ready, 0);
        chk("R6 code zero without command", vref_code, 0);
        enable = 1'b0;
        idle(3);
        chk("R9 off from hold", drv_en, 0);

        // R4 preset mode with swapped addresses
        pgood = 1'b0; swap_strap = 1'b1;
        idle(2);
        pgood = 1'b1; swap_strap = 1'b0; init_hi = 1'b1; enable = 1'b1;
        idle(2);
        chk("R10 swapped in run", core_addr, 1);
        chk("R4 drv on", drv_en, 1);
        for (int k = 1; k <= 442; k++) begin
            do_tick();
            e = (k * RATE) / 16;
            if (e > 220) e = 220;
            chk("R4 preset ramp", vref_code, e);
            chk("R4 ready timing", ready, (k > 440) ? 1 : 0);
        end

        // R7 power-good loss
        @(negedge clk) pgood = 1'b0;
        #1;
        chk("R7 ready drops on pgood", ready, 0);
        @(negedge clk);
        shut_sweep(220, 0, "pgood");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule